// File: doc/BRIEF.md
# Toggle-On-Write Interrupt Controller

This block collects four interrupt sources from the levels of a pair of transfer FIFOs into one interrupt line. A write-side FIFO and a read-side FIFO report their occupancy counts and their empty and full flags. From these inputs the block derives four conditions:

- the write FIFO has drained below half its size;
- the read FIFO has filled beyond half its size;
- the write FIFO has become empty;
- the read FIFO has become full.

Each condition latches into a bit of a status register. Software changes a latched bit by writing a 1 to its position, and that write inverts the bit. This lets software clear a bit, and also lets it set one deliberately.

A per-source mask register decides which latched bits may raise the interrupt. A single global enable bit gates the combined result. The interrupt output comes from a register, so it is free of glitches. Software reaches the three registers through a plain register port: byte address, write strobe, write data, and combinational read data.

Top module: `toc_irq_ctrl`

## Requirements
- R1: Status bit 0 is set in every cycle in which the write FIFO level is strictly below half the write FIFO size. It stays 1 while that holds, and a toggle write cannot clear it during that time.
- R2: Status bit 1 is set in every cycle in which the read FIFO level is strictly above half the read FIFO size.
- R3: Status bit 2 is set on the rising edge of the write-empty flag only. If software clears the bit while the flag stays high, the bit stays 0.
- R4: Status bit 3 is set on the rising edge of the read-full flag only.
- R5: A write to the status register at offset 0x020 inverts each of bits 3:0 where the write data holds a 1. Bits where the data holds a 0 are unchanged, and data bits 31:4 are ignored.
- R6: When a hardware set and a software toggle hit the same status bit in the same cycle, the bit ends up 1.
- R7: The mask register at offset 0x028 holds one enable per source in bits 3:0, at the same positions as the status bits. It reads back what was written.
- R8: The global enable is bit 31 of offset 0x01C. While it is 0, the interrupt output is 0.
- R9: The interrupt output is 1 exactly one cycle after a cycle in which the global enable is 1 and some status bit is 1 with its mask bit also 1.
- R10: After reset, status, mask, global enable and the interrupt output are all 0.
- R11: Reads of unmapped offsets, and of unused bit positions in mapped registers, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| wr_fifo_level | input | 7 | Write FIFO occupancy (WFIFO_DEPTH=64) |
| rd_fifo_level | input | 8 | Read FIFO occupancy (RFIFO_DEPTH=128) |
| wr_fifo_empty | input | 1 | Write FIFO empty flag |
| rd_fifo_full | input | 1 | Read FIFO full flag |
| irq | output | 1 | Registered interrupt output |

## Verification
The bench drives the threshold inputs exactly at the half point and one count away on either side. A design that used a non-strict comparison would latch a source at exactly half, and the bench would catch it there.

The bench also clears an edge-triggered bit while its flag is still high. A design that set these bits on the level would re-set the bit at once. It then raises a flag in the same cycle as a toggle write to that bit, so a design where the toggle won would leave the bit 0.

For the interrupt, the bench samples the output in the first cycle after an enable write and again one cycle later. An output driven directly from logic would already show the new value in the first sample, and an output delayed by an extra stage would still be 0 in the second.

// File: rtl/toc_pkg.sv
package toc_pkg;
  localparam int NSRC = 4;

  localparam int SRC_WR_LOW  = 0;
  localparam int SRC_RD_HIGH = 1;
  localparam int SRC_WR_EMPT = 2;
  localparam int SRC_RD_FULL = 3;

  localparam logic [11:0] OFS_GLOBAL = 12'h01C;
  localparam logic [11:0] OFS_STATUS = 12'h020;
  localparam logic [11:0] OFS_ENABLE = 12'h028;

  localparam int GLOBAL_BIT = 31;

  // true while a level sits strictly under half of the FIFO size
  function automatic logic under_half(input int unsigned lvl, input int unsigned depth);
    return lvl < (depth / 2);
  endfunction

  // true while a level sits strictly over half of the FIFO size
  function automatic logic over_half(input int unsigned lvl, input int unsigned depth);
    return lvl > (depth / 2);
  endfunction
endpackage

// File: rtl/toc_source_detect.sv
module toc_source_detect
  import toc_pkg::*;
#(
  parameter int WFIFO_DEPTH = 64,
  parameter int RFIFO_DEPTH = 128,
  parameter int WLVL_W      = $clog2(WFIFO_DEPTH + 1),
  parameter int RLVL_W      = $clog2(RFIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WLVL_W-1:0] wr_fifo_level,
  input  logic [RLVL_W-1:0] rd_fifo_level,
  input  logic              wr_fifo_empty,
  input  logic              rd_fifo_full,
  output logic [NSRC-1:0]   set_vec
);
  localparam int NEDGE = 2;

  logic [NEDGE-1:0] flag_now;
  logic [NEDGE-1:0] flag_prev;
  logic [NEDGE-1:0] flag_rise;

  assign flag_now = {rd_fifo_full, wr_fifo_empty};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_prev <= '0;
    else        flag_prev <= flag_now;
  end

  for (genvar e = 0; e < NEDGE; e++) begin : g_edge
    assign flag_rise[e] = flag_now[e] & ~flag_prev[e];
  end

  assign set_vec[SRC_WR_LOW]  = under_half(int'(wr_fifo_level), WFIFO_DEPTH);
  assign set_vec[SRC_RD_HIGH] = over_half(int'(rd_fifo_level), RFIFO_DEPTH);
  assign set_vec[SRC_WR_EMPT] = flag_rise[0];
  assign set_vec[SRC_RD_FULL] = flag_rise[1];

  // R3/R4: a flag that was already high last cycle produces no set pulse
  assert_edge_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fifo_empty |=> (wr_fifo_empty |-> !set_vec[SRC_WR_EMPT]));
  assert_edge_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fifo_full |=> (rd_fifo_full |-> !set_vec[SRC_RD_FULL]));
endmodule

// File: rtl/toc_status_reg.sv
module toc_status_reg
  import toc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic            tog_en,
  input  logic [NSRC-1:0] tog_mask,
  output logic [NSRC-1:0] status
);
  logic [NSRC-1:0] tog_vec;
  logic [NSRC-1:0] status_nxt;

  assign tog_vec = tog_en ? tog_mask : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    // a hardware set overrides a simultaneous toggle
    assign status_nxt[i] = set_vec[i] | (status[i] ^ tog_vec[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_nxt;
  end

  // R6 / R1 / R2: any set pulse leaves its bit at 1 next cycle
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));
  // R5: toggle inverts exactly the masked bits when no set is pending
  assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_en && set_vec == '0) |=> (status == ($past(status) ^ $past(tog_mask))));
  // R5: with no write and no set the status holds
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tog_en && set_vec == '0) |=> $stable(status));
endmodule

// File: rtl/toc_irq_ctrl.sv
module toc_irq_ctrl
  import toc_pkg::*;
#(
  parameter int WFIFO_DEPTH = 64,
  parameter int RFIFO_DEPTH = 128,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int WLVL_W      = $clog2(WFIFO_DEPTH + 1),
  parameter int RLVL_W      = $clog2(RFIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [WLVL_W-1:0] wr_fifo_level,
  input  logic [RLVL_W-1:0] rd_fifo_level,
  input  logic              wr_fifo_empty,
  input  logic              rd_fifo_full,
  output logic              irq
);
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] status;
  logic [NSRC-1:0] enable_q;
  logic            gie_q;
  logic            hit_global, hit_status, hit_enable;
  logic            wr_global, wr_status, wr_enable;
  logic            irq_nxt;

  assign hit_global = (reg_addr == ADDR_W'(OFS_GLOBAL));
  assign hit_status = (reg_addr == ADDR_W'(OFS_STATUS));
  assign hit_enable = (reg_addr == ADDR_W'(OFS_ENABLE));
  assign wr_global  = reg_wr & hit_global;
  assign wr_status  = reg_wr & hit_status;
  assign wr_enable  = reg_wr & hit_enable;

  toc_source_detect #(
    .WFIFO_DEPTH(WFIFO_DEPTH),
    .RFIFO_DEPTH(RFIFO_DEPTH),
    .WLVL_W     (WLVL_W),
    .RLVL_W     (RLVL_W)
  ) i_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_fifo_level(wr_fifo_level),
    .rd_fifo_level(rd_fifo_level),
    .wr_fifo_empty(wr_fifo_empty),
    .rd_fifo_full (rd_fifo_full),
    .set_vec      (set_vec)
  );

  toc_status_reg i_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .tog_en  (wr_status),
    .tog_mask(reg_wdata[NSRC-1:0]),
    .status  (status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      gie_q    <= 1'b0;
    end else begin
      if (wr_enable) enable_q <= reg_wdata[NSRC-1:0];
      if (wr_global) gie_q    <= reg_wdata[GLOBAL_BIT];
    end
  end

  assign irq_nxt = gie_q & (|(status & enable_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_nxt;
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_global)      reg_rdata[GLOBAL_BIT] = gie_q;
    else if (hit_status) reg_rdata[NSRC-1:0]   = status;
    else if (hit_enable) reg_rdata[NSRC-1:0]   = enable_q;
  end

  // R8: a cleared global enable keeps the line low next cycle
  assert_gie_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |=> !irq);
  // R9: an enabled pending source drives the line next cycle
  assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_q && (status & enable_q) != '0) |=> irq);
  // R11: unmapped offsets read as zero
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_global && !hit_status && !hit_enable) |-> (reg_rdata == '0));
endmodule

// File: tb/test_toc_irq_ctrl.sv
module test_toc_irq_ctrl;
  localparam int WD = 64;
  localparam int RD = 128;
  localparam logic [11:0] A_GLB = 12'h01C;
  localparam logic [11:0] A_STS = 12'h020;
  localparam logic [11:0] A_ENA = 12'h028;

  typedef struct packed {
    logic [7:0] wl;
    logic [7:0] rl;
    logic [1:0] exp;   // {bit1, bit0} expected in status
  } vec_t;

  // threshold probes around the half points (32 of 64, 64 of 128)
  localparam vec_t VECS [7] = '{
    '{wl: 8'd0,  rl: 8'd0,   exp: 2'b01},
    '{wl: 8'd31, rl: 8'd64,  exp: 2'b01},
    '{wl: 8'd32, rl: 8'd64,  exp: 2'b00},
    '{wl: 8'd33, rl: 8'd65,  exp: 2'b10},
    '{wl: 8'd64, rl: 8'd128, exp: 2'b10},
    '{wl: 8'd32, rl: 8'd127, exp: 2'b10},
    '{wl: 8'd1,  rl: 8'd100, exp: 2'b11}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  wr_fifo_level = 7'd32;
  logic [7:0]  rd_fifo_level = 8'd64;
  logic        wr_fifo_empty = 1'b0;
  logic        rd_fifo_full = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  toc_irq_ctrl i_toc_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wr_fifo_level(wr_fifo_level), .rd_fifo_level(rd_fifo_level),
    .wr_fifo_empty(wr_fifo_empty), .rd_fifo_full(rd_fifo_full), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R10 reset state
    rd_reg(A_STS, v); check("R10 status", v, 32'h0);
    rd_reg(A_ENA, v); check("R10 enable", v, 32'h0);
    rd_reg(A_GLB, v); check("R10 global", v, 32'h0);
    check("R10 irq", {31'h0, irq}, 32'h0);

    // R1/R2 threshold table
    for (int i = 0; i < 7; i++) begin
      wr_fifo_level = VECS[i].wl[6:0];
      rd_fifo_level = VECS[i].rl;
      tick();
      rd_reg(A_STS, v);
      check(VECS[i].exp[0] ? "R1 below half" : "R1 not below", {31'h0, v[0]}, {31'h0, VECS[i].exp[0]});
      check(VECS[i].exp[1] ? "R2 above half" : "R2 not above", {31'h0, v[1]}, {31'h0, VECS[i].exp[1]});
      if (VECS[i].exp[0]) begin
        wr_reg(A_STS, 32'h1);   // R1: condition still holds, bit stays
        rd_reg(A_STS, v); check("R1 held", {31'h0, v[0]}, 32'h1);
      end
      wr_fifo_level = 7'd32; rd_fifo_level = 8'd64;
      tick();
      rd_reg(A_STS, v);
      wr_reg(A_STS, {28'h0, v[3:0]});
      rd_reg(A_STS, v); check("R5 cleared", v, 32'h0);
    end

    // R3 edge-only set for write-empty
    wr_fifo_empty = 1'b1; tick();
    rd_reg(A_STS, v); check("R3 rise sets", v, 32'h4);
    wr_reg(A_STS, 32'h4);
    rd_reg(A_STS, v); check("R3 clear while high", v, 32'h0);
    tick();
    rd_reg(A_STS, v); check("R3 no relatch", v, 32'h0);
    wr_fifo_empty = 1'b0; tick();

    // R5 toggle semantics
    wr_reg(A_STS, 32'h0);
    rd_reg(A_STS, v); check("R5 zero write", v, 32'h0);
    wr_reg(A_STS, 32'h4);
    rd_reg(A_STS, v); check("R5 soft set", v, 32'h4);
    wr_reg(A_STS, 32'hFFFF_FFF0);
    rd_reg(A_STS, v); check("R5 upper ignored", v, 32'h4);

    // R6 set and toggle in the same cycle
    wr_fifo_empty = 1'b1;
    wr_reg(A_STS, 32'h4);
    rd_reg(A_STS, v); check("R6 edge set wins", v, 32'h4);
    wr_fifo_level = 7'd0; tick();
    wr_reg(A_STS, 32'h1);
    rd_reg(A_STS, v); check("R6 level set wins", v, 32'h5);
    wr_fifo_level = 7'd32; tick();
    wr_reg(A_STS, 32'h1);
    rd_reg(A_STS, v); check("R6 cleared after", v, 32'h4);

    // R4 edge-only set for read-full
    rd_fifo_full = 1'b1; tick();
    rd_reg(A_STS, v); check("R4 rise sets", v, 32'hC);
    wr_reg(A_STS, 32'h8);
    tick();
    rd_reg(A_STS, v); check("R4 no relatch", v, 32'h4);

    // R7 enable register
    wr_reg(A_ENA, 32'hFFFF_FFFA);
    rd_reg(A_ENA, v); check("R7 readback", v, 32'hA);

    // R8 / R9 interrupt path; status=4
    check("R8 gie off irq", {31'h0, irq}, 32'h0);
    wr_reg(A_GLB, 32'hFFFF_FFFF);
    rd_reg(A_GLB, v); check("R8 gie readback", v, 32'h8000_0000);
    tick();
    check("R9 masked source", {31'h0, irq}, 32'h0);
    wr_reg(A_ENA, 32'h4);
    check("R9 one cycle latency", {31'h0, irq}, 32'h0);
    tick();
    check("R9 irq raised", {31'h0, irq}, 32'h1);
    wr_reg(A_STS, 32'h4);
    tick();
    check("R9 irq drops", {31'h0, irq}, 32'h0);
    wr_reg(A_STS, 32'h4);
    tick();
    check("R9 irq again", {31'h0, irq}, 32'h1);
    wr_reg(A_GLB, 32'h7FFF_FFFF);
    tick();
    check("R8 gie cleared", {31'h0, irq}, 32'h0);

    // R11 unused offsets
    rd_reg(12'h024, v); check("R11 gap", v, 32'h0);
    rd_reg(12'h100, v); check("R11 far", v, 32'h0);
    rd_reg(A_GLB, v);   check("R11 gie low bits", v, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule